// File: doc/BRIEF.md
# Shared Soft-Start Ramp Arbiter

Two regulator channels share one reference-ramp generator. When a channel is enabled, the generator starts its reference code at zero. The code then climbs by one LSB every `STEP_CYCLES` clocks until it reaches `TARGET_CODE`. At that point the channel settles on the target, and a one-cycle done pulse tells downstream logic to start its power-good and undervoltage arming timers. Choose `STEP_CYCLES` as the soft-start time (nominally 1.2 ms, within 0.85 to 1.40 ms) divided by `TARGET_CODE` clock periods.

Because there is only one generator, a channel enabled while the other channel is ramping is queued. It starts from zero on the same edge that the running ramp completes. Two enables that rise in the same cycle share a single ramp.

Each channel also receives a code for its residual output level, which is left over from an unfinished discharge. The channel's switching-release output stays low during the ramp until the ramped reference reaches that level.

Top module: `ss_ramp_arbiter`

## Requirements
- R1: While reset is asserted and directly after it, all reference codes are zero and all busy, done and switch-release outputs are low.
- R2: The enable is first sampled high at edge e0, with the generator free. After m further edges the channel's reference equals floor(m / STEP_CYCLES). It therefore starts at zero and rises by exactly one LSB at a time.
- R3: The reference equals `TARGET_CODE` at edge e0 + TARGET_CODE*STEP_CYCLES. At the next edge the channel settles: `done_o` is high for exactly one cycle and the reference holds `TARGET_CODE` for as long as the enable stays high.
- R4: `busy_o` is high while a channel is queued or ramping. It is low once the channel has settled or is disabled.
- R5: Enables that rise in the same cycle with the generator free make both channels ramp together. Their references are equal in every cycle and they signal done in the same cycle.
- R6: A channel enabled while the other channel is ramping is queued. While queued it shows reference 0, busy high and switch-release low. It starts ramping from zero at the edge where the other ramp completes, and its done pulse follows TARGET_CODE*STEP_CYCLES+1 edges later.
- R7: Dropping the enable of a queued channel clears its busy flag at the next edge. The other channel's ramp and done timing are unchanged.
- R8: When an enable goes low, at the next edge that channel's reference is 0, busy and switch-release are low, and no done pulse is produced. If that channel was the only one ramping, a queued channel starts its ramp at that same edge.
- R9: During a ramp, `sw_o` goes high in the first cycle in which the reference is at or above the channel's `resid_i` code. It stays high for the rest of the ramp and in the settled state. With a residual above the target, release comes at settling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 2 | Per-channel enable |
| resid_i | input | 2 x CODE_W | Per-channel residual output level code |
| ref_o | output | 2 x CODE_W | Per-channel reference code |
| busy_o | output | 2 | Channel queued or ramping |
| done_o | output | 2 | One-cycle pulse when the channel settles |
| sw_o | output | 2 | Switching released for the channel |

## Verification
The main function is driven with a sweep of residual levels: zero, one LSB, mid-ramp, exactly the target and above the target. These cases separate an off-by-one in the compare or the step prescaler from a release that only happens at settling.

Ramps are then started in three ways: alone, by two same-cycle enables, and with a late enable. These show whether the generator is shared, restarted or wrongly run twice.

Dropping an enable while queued, and dropping the ramping channel while the other waits, shows whether the queue is released on the correct edge.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_WAIT = 2'd1,
    CH_RAMP = 2'd2,
    CH_SET  = 2'd3
  } ch_state_e;
endpackage

// File: rtl/ssr_step_gen.sv
module ssr_step_gen #(
  parameter int CODE_W      = 8,
  parameter int TARGET_CODE = 200,
  parameter int STEP_CYCLES = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  output logic [CODE_W-1:0] code_o,
  output logic              top_o
);
  localparam int PRE_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(STEP_CYCLES - 1);
  localparam logic [CODE_W-1:0] TGT      = CODE_W'(TARGET_CODE);

  logic [PRE_W-1:0]  pre_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      code_q <= '0;
    end else if (start_i || !run_i) begin
      pre_q  <= '0;
      code_q <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q  <= '0;
      code_q <= code_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end

  assign code_o = code_q;
  assign top_o  = (code_q == TGT);
endmodule

// File: rtl/ssr_chan.sv
module ssr_chan
  import ssr_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int TARGET_CODE = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              gen_free_i,
  input  logic              fin_i,
  input  logic [CODE_W-1:0] gen_code_i,
  input  logic [CODE_W-1:0] resid_i,
  output logic              ramping_o,
  output logic              enter_o,
  output logic [CODE_W-1:0] ref_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sw_o
);
  localparam logic [CODE_W-1:0] TGT = CODE_W'(TARGET_CODE);

  ch_state_e state_q, state_d;
  logic      done_q, sw_q, reached;

  assign reached = (gen_code_i >= resid_i);

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = CH_OFF;
    end else begin
      case (state_q)
        CH_OFF, CH_WAIT: state_d = gen_free_i ? CH_RAMP : CH_WAIT;
        CH_RAMP:         state_d = fin_i ? CH_SET : CH_RAMP;
        default:         state_d = CH_SET;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_OFF;
      done_q  <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == CH_RAMP) && (state_d == CH_SET);
      // sticky release, cleared on any fresh ramp entry
      sw_q    <= (state_q == CH_RAMP) && (state_d == CH_RAMP) && (sw_q || reached);
    end
  end

  assign ramping_o = (state_q == CH_RAMP);
  assign enter_o   = en_i && ((state_q == CH_OFF) || (state_q == CH_WAIT)) && gen_free_i;
  assign busy_o    = (state_q == CH_WAIT) || (state_q == CH_RAMP);
  assign done_o    = done_q;
  assign ref_o     = (state_q == CH_SET)  ? TGT :
                     (state_q == CH_RAMP) ? gen_code_i : '0;
  assign sw_o      = (state_q == CH_SET) ||
                     ((state_q == CH_RAMP) && (sw_q || reached));
endmodule

// File: rtl/ss_ramp_arbiter.sv
module ss_ramp_arbiter
  import ssr_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int TARGET_CODE = 200,
  parameter int STEP_CYCLES = 600
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_CH-1:0]              en_i,
  input  logic [NUM_CH-1:0][CODE_W-1:0]  resid_i,
  output logic [NUM_CH-1:0][CODE_W-1:0]  ref_o,
  output logic [NUM_CH-1:0]              busy_o,
  output logic [NUM_CH-1:0]              done_o,
  output logic [NUM_CH-1:0]              sw_o
);
  logic [NUM_CH-1:0] ramping, enter;
  logic [CODE_W-1:0] gen_code;
  logic              gen_top, fin, gen_free, start, run;

  // generator is free when no enabled channel keeps ramping, or the ramp ends now
  assign fin      = (|ramping) && gen_top;
  assign gen_free = ~|(ramping & en_i) || fin;
  assign start    = |enter;
  assign run      = (|(ramping & en_i)) && !fin;

  ssr_step_gen #(
    .CODE_W     (CODE_W),
    .TARGET_CODE(TARGET_CODE),
    .STEP_CYCLES(STEP_CYCLES)
  ) u_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (run),
    .code_o (gen_code),
    .top_o  (gen_top)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ssr_chan #(
      .CODE_W     (CODE_W),
      .TARGET_CODE(TARGET_CODE)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i[c]),
      .gen_free_i(gen_free),
      .fin_i     (fin),
      .gen_code_i(gen_code),
      .resid_i   (resid_i[c]),
      .ramping_o (ramping[c]),
      .enter_o   (enter[c]),
      .ref_o     (ref_o[c]),
      .busy_o    (busy_o[c]),
      .done_o    (done_o[c]),
      .sw_o      (sw_o[c])
    );
  end
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
  import ssr_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int TARGET_CODE = 200
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_CH-1:0]              en_i,
  input logic [NUM_CH-1:0][CODE_W-1:0]  ref_o,
  input logic [NUM_CH-1:0]              busy_o,
  input logic [NUM_CH-1:0]              done_o,
  input logic [NUM_CH-1:0]              sw_o
);
  localparam logic [CODE_W-1:0] TGT = CODE_W'(TARGET_CODE);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[c] |=> !done_o[c]); // R3

    AST_DONE_AT_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o[c] |-> (ref_o[c] == TGT) && !busy_o[c]); // R3

    AST_REF_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o[c] && $past(busy_o[c]) |->
        (ref_o[c] == $past(ref_o[c])) || (ref_o[c] == $past(ref_o[c]) + 1'b1)); // R2

    AST_OFF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[c] |=> !sw_o[c] && !busy_o[c] && !done_o[c] && (ref_o[c] == '0)); // R8

    AST_SW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(sw_o[c]) && busy_o[c] && $past(busy_o[c]) |-> sw_o[c]); // R9
  end

  AST_SHARED_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o[0] && busy_o[1] && (ref_o[0] != '0) && (ref_o[1] != '0)
      |-> ref_o[0] == ref_o[1]); // R5
endmodule

bind ss_ramp_arbiter ssr_checker #(
  .CODE_W     (CODE_W),
  .TARGET_CODE(TARGET_CODE)
) u_ssr_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .en_i  (en_i),
  .ref_o (ref_o),
  .busy_o(busy_o),
  .done_o(done_o),
  .sw_o  (sw_o)
);

// File: tb/test_ss_ramp_arbiter.sv
`timescale 1ns/1ps
module test_ss_ramp_arbiter;
  localparam int CW = 6;
  localparam int T  = 10;
  localparam int S  = 3;
  localparam int RAMP_K = T*S + 2;   // done sample index counted from enable
  localparam int NV = 5;
  localparam int VEC_RES [NV] = '{0, 1, 4, 10, 12};
  localparam int VEC_K   [NV] = '{1, 4, 13, 31, 32};
  localparam int VEC_REF [NV] = '{0, 1, 4, 10, 10};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        en = '0;
  logic [1:0][CW-1:0] resid = '0;
  logic [1:0][CW-1:0] refc;
  logic [1:0]        busy, done, sw;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ss_ramp_arbiter #(.CODE_W(CW), .TARGET_CODE(T), .STEP_CYCLES(S)) i_ss_ramp_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .resid_i(resid),
    .ref_o(refc), .busy_o(busy), .done_o(done), .sw_o(sw));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiesce();
    en = '0;
    tick();
    tick();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    int k;
    // R1 reset state
    @(negedge clk);
    check("R1 ref", refc, 0);
    check("R1 busy/done/sw", {busy, done, sw}, 0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R1 after reset", {busy, done, sw, refc}, 0);

    // R9 residual sweep, table walk
    for (int v = 0; v < NV; v++) begin
      quiesce();
      resid[0] = CW'(VEC_RES[v]);
      en[0] = 1'b1;
      k = 0;
      while (!sw[0] && k < 100) begin
        tick();
        k++;
      end
      check("R9 release cycle", k, VEC_K[v]);
      check("R9 ref at release", refc[0], VEC_REF[v]);
    end

    // R2 R3 R4 single ramp profile
    quiesce();
    resid = '0;
    en[0] = 1'b1;
    for (int i = 1; i <= RAMP_K + 2; i++) begin
      tick();
      check("R2 ref", refc[0], (i <= T*S + 1) ? (i - 1) / S : T);
      check("R3 done", done[0], (i == RAMP_K) ? 1 : 0);
      check("R4 busy", busy[0], (i < RAMP_K) ? 1 : 0);
    end

    // R5 simultaneous enables
    quiesce();
    en = 2'b11;
    for (int i = 1; i <= RAMP_K; i++) begin
      tick();
      check("R5 equal ref", refc[1], refc[0]);
      check("R5 done ch0", done[0], (i == RAMP_K) ? 1 : 0);
      check("R5 done ch1", done[1], (i == RAMP_K) ? 1 : 0);
    end

    // R6 queued late enable
    quiesce();
    resid[1] = '0;
    en[0] = 1'b1;
    repeat (5) tick();
    en[1] = 1'b1;
    tick();
    check("R6 queued busy", busy[1], 1);
    check("R6 queued ref", refc[1], 0);
    check("R6 queued sw", sw[1], 0);
    k = 6;
    while (!done[0] && k < 100) begin
      tick();
      k++;
    end
    check("R6 first done", k, RAMP_K);
    check("R6 second starts", {busy[1], 1'b0} | refc[1], 2);
    k = 0;
    while (!done[1] && k < 100) begin
      tick();
      k++;
    end
    check("R6 second done", k, T*S + 1);

    // R7 dequeue while queued
    quiesce();
    en[0] = 1'b1;
    repeat (4) tick();
    en[1] = 1'b1;
    repeat (2) tick();
    check("R7 queued busy", busy[1], 1);
    en[1] = 1'b0;
    tick();
    check("R7 dequeued busy", busy[1], 0);
    k = 7;
    while (!done[0] && k < 100) begin
      tick();
      k++;
    end
    check("R7 other done timing", k, RAMP_K);
    check("R7 no done on dropped", done[1], 0);

    // R8 drop ramping channel while other is queued
    quiesce();
    en[0] = 1'b1;
    repeat (3) tick();
    en[1] = 1'b1;
    repeat (6) tick();
    en[0] = 1'b0;
    tick();
    check("R8 dropped ref", refc[0], 0);
    check("R8 dropped busy/sw", {busy[0], sw[0]}, 0);
    check("R8 queued starts", {busy[1], refc[1] == 0}, 2'b11);
    k = 0;
    while (!done[1] && k < 100) begin
      check("R8 no done on dropped", done[0], 0);
      tick();
      k++;
    end
    check("R8 queued done timing", k, T*S + 1);

    quiesce();
    summary();
  end
endmodule